// File: doc/BRIEF.md
# PTP Event Message Timestamper

This block serves one switch port. It watches the frame byte stream the port receives and the frame byte stream it sends. In each stream it looks for precision time protocol (version 1) event messages carried over IPv4/UDP. When it finds one that matches, it keeps three things in that direction's capture registers:

- the free-running 64-bit time, as it stood on the first byte of the frame;
- the sender's 48-bit identity;
- the 16-bit sequence number.

Which message type counts as a match depends on the role of the node, and the choice is mirrored between the two directions:

| Role | Transmit side matches | Receive side matches |
|------|-----------------------|----------------------|
| Master | Sync | Delay_Req |
| Slave | Delay_Req | Sync |

Each direction raises its own interrupt flag when it captures. The host clears that flag by writing 1 to it. A capture that lands while the flag is still set overwrites the registers and sets a sticky overrun bit.

Several instances may share one time source. The byte streams have no back-pressure: the block accepts every beat on which valid is high, so the source never waits. A beat on which valid is low carries nothing, and the stream may pause at any point.

Top module: `ptp_event_stamper`

## Requirements
- R1: After reset, all capture registers read zero, and both interrupt flags and both overrun bits are low.
- R2: With `ptp_master` high, the transmit side captures only frames whose control byte (frame offset 74) is 0 (Sync), and the receive side captures only frames whose control byte is 1 (Delay_Req).
- R3: With `ptp_master` low, the roles are swapped: the transmit side captures control byte 1 and the receive side captures control byte 0.
- R4: The captured time equals the value of `time_now` on the beat that carries `sof`. The capture registers and the flag change on the second rising edge that follows the beat carrying `eof`.
- R5: The identity is taken from frame offsets 64..69 and the sequence number from offsets 72..73, first byte most significant. These are PTP header offsets 22..27 and 30..31, behind a 14-byte Ethernet header, a 20-byte IPv4 header and an 8-byte UDP header.
- R6: A frame qualifies only if all of these hold: offsets 12..13 are 0x08 0x00; offset 14 is 0x45; offset 23 is 17; offsets 36..37 are 0x01 0x3F (UDP destination port 319). If any one of these bytes differs, there is no capture.
- R7: A frame that ends before offset 74, or whose control byte does not match, causes no capture. A frame whose last byte is offset 74 can still qualify.
- R8: A capture sets that direction's flag. Asserting that direction's `irq_clr` bit without a capture on the same edge clears the flag. A capture on the same edge as a clear leaves the flag set.
- R9: A capture while the flag is set, with no clear on that edge, overwrites the registers and sets the overrun bit. The overrun bit stays set until that direction's `ovr_clr` bit is asserted.
- R10: The receive and transmit directions run independently and can capture on the same cycle.
- R11: Beats with `valid` low are ignored. So are valid beats outside a frame, meaning before any `sof` or after `eof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptp_master | input | 1 | 1 = node is master, 0 = slave |
| time_now | input | 64 | Shared free-running time |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Receive first byte of frame |
| rx_eof | input | 1 | Receive last byte of frame |
| rx_data | input | 8 | Receive byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_sof | input | 1 | Transmit first byte of frame |
| tx_eof | input | 1 | Transmit last byte of frame |
| tx_data | input | 8 | Transmit byte |
| irq_clr | input | 2 | Write-1 flag clear, bit 0 receive, bit 1 transmit |
| ovr_clr | input | 2 | Overrun clear, bit 0 receive, bit 1 transmit |
| rx_cap_time | output | 64 | Receive captured time |
| rx_cap_uuid | output | 48 | Receive captured identity |
| rx_cap_seq | output | 16 | Receive captured sequence number |
| rx_irq | output | 1 | Receive capture flag |
| rx_ovr | output | 1 | Receive overrun |
| tx_cap_time | output | 64 | Transmit captured time |
| tx_cap_uuid | output | 48 | Transmit captured identity |
| tx_cap_seq | output | 16 | Transmit captured sequence number |
| tx_irq | output | 1 | Transmit capture flag |
| tx_ovr | output | 1 | Transmit overrun |

## Verification
The bench sends frames in both roles with both control values, so a design that wires the role select the wrong way round shows captures on the wrong side or misses them. It spoils each header byte that decides qualification, one at a time. It also ends frames one byte before the control byte and exactly on it: a parser off by one either captures the short frame or drops the legal one. Frames with gaps, and frames in which the time moves on, show whether the time is taken at the first byte. A flag clear that lands on the same edge as a capture, and a second capture while the flag is still set, expose a design that lets the clear win or that fails to set or hold the overrun bit.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

  localparam int unsigned ETYPE_HI_POS = 12;
  localparam int unsigned ETYPE_LO_POS = 13;
  localparam int unsigned IP_VHL_POS   = 14;
  localparam int unsigned IP_PROTO_POS = 23;
  localparam int unsigned UDP_DPH_POS  = 36;
  localparam int unsigned UDP_DPL_POS  = 37;
  localparam int unsigned UUID_FIRST   = 64;
  localparam int unsigned UUID_LAST    = 69;
  localparam int unsigned SEQ_FIRST    = 72;
  localparam int unsigned SEQ_LAST     = 73;
  localparam int unsigned CTRL_POS     = 74;

  localparam logic [7:0] CTRL_SYNC = 8'd0;
  localparam logic [7:0] CTRL_DREQ = 8'd1;

  // Transmit+master and receive+slave both look for Sync; the other two pairs look for Delay_Req.
  function automatic logic [7:0] role_ctrl(dir_e d, logic master);
    return ((d == DIR_TX) == master) ? CTRL_SYNC : CTRL_DREQ;
  endfunction

  // Tells whether the byte at a given offset meets the qualification rule for that offset.
  function automatic logic hdr_byte_ok(int unsigned pos, logic [7:0] d,
                                       logic [7:0] ctrl, logic [15:0] port);
    logic ok;
    case (pos)
      ETYPE_HI_POS: ok = (d == 8'h08);
      ETYPE_LO_POS: ok = (d == 8'h00);
      IP_VHL_POS:   ok = (d == 8'h45);
      IP_PROTO_POS: ok = (d == 8'd17);
      UDP_DPH_POS:  ok = (d == port[15:8]);
      UDP_DPL_POS:  ok = (d == port[7:0]);
      CTRL_POS:     ok = (d == ctrl);
      default:      ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ptp_evt_parser.sv
module ptp_evt_parser
  import ptp_ts_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int POS_W    = 7,
  parameter int UUID_W   = 48,
  parameter int SEQ_W    = 16,
  parameter logic [15:0] EVT_PORT = 16'd319
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_eof,
  input  logic [7:0]        s_data,
  input  logic [7:0]        want_ctrl,
  input  logic [TIME_W-1:0] time_now,
  output logic              commit,
  output logic [TIME_W-1:0] pend_time,
  output logic [UUID_W-1:0] pend_uuid,
  output logic [SEQ_W-1:0]  pend_seq
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] idx;
  logic [POS_W-1:0] pos;
  logic             in_frame;
  logic             hdr_ok;
  logic             beat;
  logic             ok_next;
  logic             long_enough;

  assign pos         = s_sof ? '0 : idx;
  assign beat        = s_valid && (s_sof || in_frame);
  assign ok_next     = (s_sof ? 1'b1 : hdr_ok) &&
                       hdr_byte_ok(int'(pos), s_data, want_ctrl, EVT_PORT);
  assign long_enough = (int'(pos) >= int'(CTRL_POS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      in_frame  <= 1'b0;
      hdr_ok    <= 1'b0;
      commit    <= 1'b0;
      pend_time <= '0;
      pend_uuid <= '0;
      pend_seq  <= '0;
    end else begin
      commit <= 1'b0;
      if (beat) begin
        idx      <= (pos == POS_MAX) ? pos : pos + 1'b1;
        in_frame <= !s_eof;
        hdr_ok   <= ok_next;
        if (s_sof) pend_time <= time_now;
        if (int'(pos) >= int'(UUID_FIRST) && int'(pos) <= int'(UUID_LAST))
          pend_uuid <= {pend_uuid[UUID_W-9:0], s_data};
        if (int'(pos) >= int'(SEQ_FIRST) && int'(pos) <= int'(SEQ_LAST))
          pend_seq <= {pend_seq[SEQ_W-9:0], s_data};
        commit <= s_eof && ok_next && long_enough;
      end
    end
  end

  // R7
  commit_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(s_valid && s_eof));

endmodule

// File: rtl/ptp_capture_bank.sv
module ptp_capture_bank #(
  parameter int TIME_W = 64,
  parameter int UUID_W = 48,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [TIME_W-1:0] pend_time,
  input  logic [UUID_W-1:0] pend_uuid,
  input  logic [SEQ_W-1:0]  pend_seq,
  input  logic              flag_clr,
  input  logic              ovr_clr,
  output logic [TIME_W-1:0] cap_time,
  output logic [UUID_W-1:0] cap_uuid,
  output logic [SEQ_W-1:0]  cap_seq,
  output logic              flag,
  output logic              ovr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_time <= '0;
      cap_uuid <= '0;
      cap_seq  <= '0;
      flag     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (commit) begin
        cap_time <= pend_time;
        cap_uuid <= pend_uuid;
        cap_seq  <= pend_seq;
      end
      flag <= commit || (flag && !flag_clr);
      if (commit && flag && !flag_clr) ovr <= 1'b1;
      else if (ovr_clr)                ovr <= 1'b0;
    end
  end

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(commit));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !commit) |=> !flag);

  // R9
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(flag && commit));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cap_time) && $stable(cap_seq) && $stable(cap_uuid));

endmodule

// File: rtl/ptp_event_stamper.sv
module ptp_event_stamper
  import ptp_ts_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int UUID_W = 48,
  parameter int SEQ_W  = 16,
  parameter logic [15:0] EVT_PORT = 16'd319
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptp_master,
  input  logic [TIME_W-1:0] time_now,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              tx_valid,
  input  logic              tx_sof,
  input  logic              tx_eof,
  input  logic [7:0]        tx_data,
  input  logic [1:0]        irq_clr,
  input  logic [1:0]        ovr_clr,
  output logic [TIME_W-1:0] rx_cap_time,
  output logic [UUID_W-1:0] rx_cap_uuid,
  output logic [SEQ_W-1:0]  rx_cap_seq,
  output logic              rx_irq,
  output logic              rx_ovr,
  output logic [TIME_W-1:0] tx_cap_time,
  output logic [UUID_W-1:0] tx_cap_uuid,
  output logic [SEQ_W-1:0]  tx_cap_seq,
  output logic              tx_irq,
  output logic              tx_ovr
);

  localparam int N_DIR = 2;
  localparam int POS_W = $clog2(CTRL_POS + 2);

  logic [N_DIR-1:0]       d_valid, d_sof, d_eof, d_commit, d_irq, d_ovr;
  logic [7:0]             d_data  [N_DIR];
  logic [TIME_W-1:0]      p_time  [N_DIR];
  logic [UUID_W-1:0]      p_uuid  [N_DIR];
  logic [SEQ_W-1:0]       p_seq   [N_DIR];
  logic [TIME_W-1:0]      c_time  [N_DIR];
  logic [UUID_W-1:0]      c_uuid  [N_DIR];
  logic [SEQ_W-1:0]       c_seq   [N_DIR];

  assign d_valid = {tx_valid, rx_valid};
  assign d_sof   = {tx_sof,   rx_sof};
  assign d_eof   = {tx_eof,   rx_eof};
  assign d_data[DIR_RX] = rx_data;
  assign d_data[DIR_TX] = tx_data;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic [7:0] want;
    assign want = role_ctrl(dir_e'(d), ptp_master);

    ptp_evt_parser #(
      .TIME_W(TIME_W), .POS_W(POS_W), .UUID_W(UUID_W),
      .SEQ_W(SEQ_W), .EVT_PORT(EVT_PORT)
    ) i_parse (
      .clk(clk), .rst_n(rst_n),
      .s_valid(d_valid[d]), .s_sof(d_sof[d]), .s_eof(d_eof[d]), .s_data(d_data[d]),
      .want_ctrl(want), .time_now(time_now),
      .commit(d_commit[d]), .pend_time(p_time[d]),
      .pend_uuid(p_uuid[d]), .pend_seq(p_seq[d])
    );

    ptp_capture_bank #(
      .TIME_W(TIME_W), .UUID_W(UUID_W), .SEQ_W(SEQ_W)
    ) i_bank (
      .clk(clk), .rst_n(rst_n),
      .commit(d_commit[d]), .pend_time(p_time[d]),
      .pend_uuid(p_uuid[d]), .pend_seq(p_seq[d]),
      .flag_clr(irq_clr[d]), .ovr_clr(ovr_clr[d]),
      .cap_time(c_time[d]), .cap_uuid(c_uuid[d]), .cap_seq(c_seq[d]),
      .flag(d_irq[d]), .ovr(d_ovr[d])
    );
  end

  assign rx_cap_time = c_time[DIR_RX];
  assign rx_cap_uuid = c_uuid[DIR_RX];
  assign rx_cap_seq  = c_seq[DIR_RX];
  assign rx_irq      = d_irq[DIR_RX];
  assign rx_ovr      = d_ovr[DIR_RX];
  assign tx_cap_time = c_time[DIR_TX];
  assign tx_cap_uuid = c_uuid[DIR_TX];
  assign tx_cap_seq  = c_seq[DIR_TX];
  assign tx_irq      = d_irq[DIR_TX];
  assign tx_ovr      = d_ovr[DIR_TX];

endmodule

// File: tb/test_ptp_event_stamper.sv
module test_ptp_event_stamper;

  typedef struct {
    logic [63:0] t;
    logic [47:0] uuid;
    logic [15:0] seq;
  } cap_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptp_master = 1'b1;
  logic [63:0] time_now = 64'h0000_1234_5678_0000;
  logic [1:0]  v = '0, so = '0, eo = '0;
  logic [7:0]  dt [2];
  logic [1:0]  mon_clr = '0, man_clr = '0, man_ovr = '0;
  logic [1:0]  mon_en = 2'b11;
  logic [1:0]  irq_clr;

  logic [63:0] rx_cap_time, tx_cap_time;
  logic [47:0] rx_cap_uuid, tx_cap_uuid;
  logic [15:0] rx_cap_seq, tx_cap_seq;
  logic        rx_irq, rx_ovr, tx_irq, tx_ovr;

  int total = 0;
  int bad = 0;
  cap_t expq [2][$];
  cap_t last [2];

  always #4 clk = ~clk;
  always @(posedge clk) time_now <= time_now + 64'd8;

  assign irq_clr = mon_clr | man_clr;

  ptp_event_stamper i_ptp_event_stamper (
    .clk(clk), .rst_n(rst_n), .ptp_master(ptp_master), .time_now(time_now),
    .rx_valid(v[0]), .rx_sof(so[0]), .rx_eof(eo[0]), .rx_data(dt[0]),
    .tx_valid(v[1]), .tx_sof(so[1]), .tx_eof(eo[1]), .tx_data(dt[1]),
    .irq_clr(irq_clr), .ovr_clr(man_ovr),
    .rx_cap_time(rx_cap_time), .rx_cap_uuid(rx_cap_uuid), .rx_cap_seq(rx_cap_seq),
    .rx_irq(rx_irq), .rx_ovr(rx_ovr),
    .tx_cap_time(tx_cap_time), .tx_cap_uuid(tx_cap_uuid), .tx_cap_seq(tx_cap_seq),
    .tx_irq(tx_irq), .tx_ovr(tx_ovr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic cap_t port_cap(int d);
    cap_t c;
    c.t    = d ? tx_cap_time : rx_cap_time;
    c.uuid = d ? tx_cap_uuid : rx_cap_uuid;
    c.seq  = d ? tx_cap_seq  : rx_cap_seq;
    return c;
  endfunction

  // Monitor: on a raised flag, compare against the oldest expected item and clear the flag.
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      logic f;
      f = d ? tx_irq : rx_irq;
      if (mon_en[d] && f && !mon_clr[d]) begin
        if (expq[d].size() == 0) begin
          check(1'b0, "R2", "unexpected capture", 64'(d), 64'hFFFF);
        end else begin
          cap_t e, a;
          e = expq[d].pop_front();
          a = port_cap(d);
          check(a.t == e.t, "R4", "captured time", a.t, e.t);
          check(a.uuid == e.uuid, "R5", "captured identity", 64'(a.uuid), 64'(e.uuid));
          check(a.seq == e.seq, "R5", "captured sequence", 64'(a.seq), 64'(e.seq));
          last[d] = e;
        end
        mon_clr[d] = 1'b1;
      end else begin
        mon_clr[d] = 1'b0;
      end
    end
  end

  // Driver: builds a frame, sends it, and pushes the expected capture when one should occur.
  task automatic send(input int d, input logic [47:0] uuid, input logic [15:0] seq,
                      input logic [7:0] ctrl, input int len, input int bad_pos,
                      input logic [7:0] bad_val, input int gap, input bit expect_cap,
                      output logic [63:0] t_sof);
    logic [7:0] f [80];
    for (int i = 0; i < 80; i++) f[i] = 8'(i * 7 + 3);
    f[12] = 8'h08; f[13] = 8'h00; f[14] = 8'h45; f[23] = 8'd17;
    f[36] = 8'h01; f[37] = 8'h3F;
    for (int i = 0; i < 6; i++) f[64 + i] = uuid[47 - 8 * i -: 8];
    f[72] = seq[15:8]; f[73] = seq[7:0]; f[74] = ctrl;
    if (bad_pos >= 0) f[bad_pos] = bad_val;
    t_sof = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      v[d] = 1'b1; so[d] = (i == 0); eo[d] = (i == len - 1); dt[d] = f[i];
      if (i == 0) t_sof = time_now;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        v[d] = 1'b0; so[d] = 1'b0; eo[d] = 1'b0; dt[d] = 8'hAA;
      end
    end
    if (expect_cap) begin
      cap_t c;
      c.t = t_sof; c.uuid = uuid; c.seq = seq;
      expq[d].push_back(c);
    end
    @(negedge clk);
    v[d] = 1'b0; so[d] = 1'b0; eo[d] = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_none(input int d, input string req);
    cap_t a;
    settle();
    a = port_cap(d);
    check(a.t == last[d].t && a.seq == last[d].seq, req, "no capture expected", a.t, last[d].t);
  endtask

  task automatic drained(input string req);
    check(expq[0].size() == 0 && expq[1].size() == 0, req, "pending expected captures",
          64'(expq[0].size() + expq[1].size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ta, tb, tc, td;
    dt[0] = '0; dt[1] = '0;
    for (int d = 0; d < 2; d++) begin
      last[d].t = '0; last[d].uuid = '0; last[d].seq = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rx_cap_time == 0 && tx_cap_time == 0 && rx_cap_uuid == 0 && tx_cap_seq == 0,
          "R1", "capture regs after reset", rx_cap_time | tx_cap_time, 64'd0);
    check({rx_irq, rx_ovr, tx_irq, tx_ovr} == 4'b0, "R1", "flags after reset",
          64'({rx_irq, rx_ovr, tx_irq, tx_ovr}), 64'd0);

    // R11: stray valid bytes outside any frame are ignored
    for (int i = 0; i < 90; i++) begin
      @(negedge clk); v[0] = 1'b1; so[0] = 1'b0; eo[0] = (i == 89); dt[0] = 8'h01;
    end
    @(negedge clk); v[0] = 1'b0; eo[0] = 1'b0;
    expect_none(0, "R11");

    // R2 and R10: master, tx Sync and rx Delay_Req on the same cycles
    ptp_master = 1'b1;
    fork
      send(1, 48'h0011_2233_4455, 16'h1001, 8'd0, 80, -1, 8'h00, 0, 1'b1, ta);
      send(0, 48'hA0B1_C2D3_E4F5, 16'h2002, 8'd1, 80, -1, 8'h00, 0, 1'b1, tb);
    join
    settle();
    drained("R10");
    // R2: wrong message types in master role
    send(1, 48'h1, 16'h3, 8'd1, 80, -1, 8'h00, 0, 1'b0, tc);
    expect_none(1, "R2");
    send(0, 48'h2, 16'h4, 8'd0, 80, -1, 8'h00, 0, 1'b0, tc);
    expect_none(0, "R2");

    // R3: slave role swaps the selection
    ptp_master = 1'b0;
    send(1, 48'h5566_7788_99AA, 16'hBEEF, 8'd1, 80, -1, 8'h00, 0, 1'b1, tc);
    send(0, 48'hFEDC_BA98_7654, 16'h0102, 8'd0, 80, -1, 8'h00, 0, 1'b1, tc);
    settle();
    drained("R3");
    send(1, 48'h7, 16'h8, 8'd0, 80, -1, 8'h00, 0, 1'b0, tc);
    expect_none(1, "R3");

    // R6: spoil each qualifying header byte in turn
    begin
      int bp [6];
      bp = '{12, 13, 14, 23, 36, 37};
      for (int k = 0; k < 6; k++) begin
        send(0, 48'h9, 16'h9, 8'd0, 80, bp[k], 8'hC3, 0, 1'b0, tc);
        expect_none(0, "R6");
      end
    end

    // R7: frame ends one byte before the control byte, then exactly on it
    send(0, 48'hAB, 16'hCD, 8'd0, 74, -1, 8'h00, 0, 1'b0, tc);
    expect_none(0, "R7");
    send(0, 48'h1234_5678_9ABC, 16'h7777, 8'd0, 75, -1, 8'h00, 0, 1'b1, tc);
    settle();
    drained("R7");

    // R11 and R4: gaps inside the frame, time still taken on the first byte
    send(1, 48'hCAFE_F00D_0001, 16'h4242, 8'd1, 80, -1, 8'h00, 2, 1'b1, tc);
    settle();
    drained("R11");

    // R8 and R9: manual flag handling on the transmit side
    mon_en[1] = 1'b0;
    send(1, 48'h0A, 16'h0A, 8'd1, 80, -1, 8'h00, 0, 1'b0, ta);
    settle();
    check(tx_irq == 1'b1 && tx_ovr == 1'b0, "R8", "flag after capture",
          64'({tx_irq, tx_ovr}), 64'b10);
    check(tx_cap_time == ta, "R4", "time first capture", tx_cap_time, ta);
    send(1, 48'h0B, 16'h0B, 8'd1, 80, -1, 8'h00, 0, 1'b0, tb);
    settle();
    check(tx_cap_time == tb && tx_cap_seq == 16'h0B, "R9", "overwrite while flagged",
          tx_cap_time, tb);
    check(tx_ovr == 1'b1, "R9", "overrun set", 64'(tx_ovr), 64'd1);
    @(negedge clk); man_clr[1] = 1'b1;
    @(negedge clk); man_clr[1] = 1'b0;
    check(tx_irq == 1'b0, "R8", "flag cleared", 64'(tx_irq), 64'd0);
    check(tx_ovr == 1'b1, "R9", "overrun sticky over flag clear", 64'(tx_ovr), 64'd1);
    @(negedge clk); man_ovr[1] = 1'b1;
    @(negedge clk); man_ovr[1] = 1'b0;
    check(tx_ovr == 1'b0, "R9", "overrun cleared", 64'(tx_ovr), 64'd0);
    send(1, 48'h0C, 16'h0C, 8'd1, 80, -1, 8'h00, 0, 1'b0, tc);
    settle();
    // The send task returns on the negedge after the eof edge: a clear here meets the capture edge.
    send(1, 48'h0D, 16'h0D, 8'd1, 80, -1, 8'h00, 0, 1'b0, td);
    man_clr[1] = 1'b1;
    @(negedge clk); man_clr[1] = 1'b0;
    check(tx_irq == 1'b1, "R8", "capture beats same-edge clear", 64'(tx_irq), 64'd1);
    check(tx_ovr == 1'b0, "R9", "no overrun when clear coincides", 64'(tx_ovr), 64'd0);
    check(tx_cap_time == td, "R4", "time of coinciding capture", tx_cap_time, td);
    @(negedge clk); man_clr[1] = 1'b1;
    @(negedge clk); man_clr[1] = 1'b0;
    last[1].t = td; last[1].seq = 16'h0D;
    mon_en[1] = 1'b1;
    check(rx_ovr == 1'b0, "R10", "receive side untouched", 64'(rx_ovr), 64'd0);

    settle();
    drained("R2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule